// File: doc/BRIEF.md
# Sampling Converter Serial Readout Port

A synthesizable model of the digital side of a 14-bit sampling converter, meant as a testbench target or an emulation stand-in. The host drives a convert strobe (`conv`) and a shift clock (`sck`). A stimulus port supplies a signed sample value. The model saturates that value into a 14-bit straight-binary code. It times each conversion with a counter on its own system clock. Afterwards it drops into an automatic nap state and waits for the host to end the conversion and read the result.

Both host lines are sampled on the system clock, and edges are detected by comparing each sample with the one before it. Every response therefore appears one system clock after the host edge is first sampled; no further pipeline stage is added. The serial pin is modelled as a data bit `sdo_data` plus an enable `sdo_oe`. A low enable stands for high impedance.

The controller has four states. `ST_IDLE` is the state after reset. `ST_CONVERT` is the timed conversion, with busy high. `ST_NAP` follows the conversion, with nap high. `ST_SHIFT` is the readout, with the pin enabled. The transitions are:
- start: IDLE→CONVERT on a rising `conv`.
- complete: CONVERT→NAP when the timer expires.
- early end: CONVERT→SHIFT on a falling `conv` before expiry, which is a protocol violation.
- release: NAP→SHIFT on a falling `conv`.
- restart: SHIFT→CONVERT on a rising `conv`.

Top module: `adc_serial_port`

## Requirements
- R1: A rising `conv` raises `busy` one clock after it is sampled. The sample code is captured at that edge, so later changes on `ain_code` do not alter the word read out.
- R2: Out of reset, `busy`, `nap`, `sdo_oe` and `viol` are 0. `sdo_oe` is 0 in every cycle that follows a cycle in which `conv` was sampled high.
- R3: One clock after a falling `conv` is sampled, `sdo_oe` is 1 and `sdo_data` carries bit 13 (the MSB) of the code.
- R4: While the pin is enabled, each `sck` fall (1 then 0 on consecutive samples) moves `sdo_data` to the next lower bit, from bit 12 down to bit 0. A rising `sck` leaves `sdo_data` unchanged.
- R5: Every `sck` fall after the one that presented bit 0 gives `sdo_data` = 0, with no limit on their number.
- R6: `busy` stays high for exactly `CONV_CYCLES` clocks (260 by default, which is 1300 ns at 200 MHz). `nap` is then high until `conv` falls. `busy` and `nap` are never high together.
- R7: A `conv` fall while `busy` is high drops `busy` and sets `viol`. The whole frame then reads as zeros. `viol` clears at the next rising `conv`.
- R8: `ain_code` is signed. Values below 0 are coded 0, values above 16383 are coded 16383 (all ones), and values in between are coded unchanged.
- R9: A rising `conv` in the middle of a readout abandons it: the pin is disabled and a new conversion starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv | input | 1 | Host convert strobe |
| sck | input | 1 | Host shift clock |
| ain_code | input | AIN_W (16) | Signed stimulus sample value |
| sdo_data | output | 1 | Serial data bit (0 when not enabled) |
| sdo_oe | output | 1 | Serial pin drive enable (0 = high impedance) |
| busy | output | 1 | Conversion in progress |
| nap | output | 1 | Automatic nap after a completed conversion |
| viol | output | 1 | Current frame ended its conversion too early |

## Verification
The bench measures the busy window cycle by cycle. A timer that is off by one in its load value or its expiry test shows up as 259 or 261 cycles. It changes `ain_code` right after the start edge, so a design that captures at the falling `conv` instead of the rising one reads out the wrong word. It clocks past the LSB to catch a shifter that wraps around or repeats bit 0 instead of filling with zeros. It ends conversions early to make sure the violation frame reads all zeros and not the stale word. It restarts in the middle of a readout and drives out-of-range values on both sides, where a wrong compare would wrap a negative value to a large code.

// File: rtl/adcp_pkg.sv
package adcp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONVERT = 2'd1,
        ST_NAP     = 2'd2,
        ST_SHIFT   = 2'd3
    } port_state_t;
endpackage

// File: rtl/adcp_clamp.sv
module adcp_clamp #(
    parameter int AIN_W = 16,
    parameter int RES   = 14
) (
    input  logic signed [AIN_W-1:0] value_in,
    output logic        [RES-1:0]   code_out
);
    localparam logic signed [AIN_W-1:0] TOP_S = AIN_W'((1 << RES) - 1);

    always_comb begin
        if (value_in < 0)
            code_out = '0;
        else if (value_in > TOP_S)
            code_out = '1;
        else
            code_out = value_in[RES-1:0];
    end
endmodule

// File: rtl/adcp_conv_timer.sv
module adcp_conv_timer #(
    parameter int CONV_CYCLES = 260
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= LOAD_V;
        else if (run && remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/adcp_shifter.sv
module adcp_shifter #(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [RES-1:0] load_word,
    input  logic           advance,
    output logic           head_bit
);
    logic [RES-1:0] sreg;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg <= '0;
        else if (load)
            sreg <= load_word;
        else if (advance)
            sreg <= {sreg[RES-2:0], 1'b0};
    end

    assign head_bit = sreg[RES-1];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adcp_pkg::*;
#(
    parameter int AIN_W       = 16,
    parameter int RES         = 14,
    parameter int CONV_CYCLES = 260
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv,
    input  logic                    sck,
    input  logic signed [AIN_W-1:0] ain_code,
    output logic                    sdo_data,
    output logic                    sdo_oe,
    output logic                    busy,
    output logic                    nap,
    output logic                    viol
);
    port_state_t state_q, state_d;

    logic conv_q, sck_q;
    logic conv_rise, conv_fall, sck_fall;
    logic start_conv, load_word, load_zero, set_viol;
    logic timer_done, head_bit;
    logic [RES-1:0] clamped, held_word, shift_src;
    logic viol_q;

    // host line history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q <= 1'b0;
            sck_q  <= 1'b0;
        end else begin
            conv_q <= conv;
            sck_q  <= sck;
        end
    end

    assign conv_rise = conv & ~conv_q;
    assign conv_fall = ~conv & conv_q;
    assign sck_fall  = ~sck & sck_q;

    adcp_clamp #(.AIN_W(AIN_W), .RES(RES)) i_clamp (
        .value_in (ain_code),
        .code_out (clamped)
    );

    adcp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_conv),
        .run     (state_q == ST_CONVERT),
        .expired (timer_done)
    );

    // next-state and action decode
    always_comb begin
        state_d    = state_q;
        start_conv = 1'b0;
        load_word  = 1'b0;
        load_zero  = 1'b0;
        set_viol   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_rise) begin
                    state_d    = ST_CONVERT;
                    start_conv = 1'b1;
                end
            end
            ST_CONVERT: begin
                if (conv_fall) begin
                    state_d = ST_SHIFT;
                    if (timer_done) begin
                        load_word = 1'b1;
                    end else begin
                        load_zero = 1'b1;
                        set_viol  = 1'b1;
                    end
                end else if (timer_done) begin
                    state_d = ST_NAP;
                end
            end
            ST_NAP: begin
                if (conv_fall) begin
                    state_d   = ST_SHIFT;
                    load_word = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (conv_rise) begin
                    state_d    = ST_CONVERT;
                    start_conv = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // captured sample and violation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            viol_q    <= 1'b0;
        end else begin
            if (start_conv)
                held_word <= clamped;
            if (start_conv)
                viol_q <= 1'b0;
            else if (set_viol)
                viol_q <= 1'b1;
        end
    end

    assign shift_src = load_zero ? '0 : held_word;

    adcp_shifter #(.RES(RES)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_word | load_zero),
        .load_word (shift_src),
        .advance   (sck_fall && state_q == ST_SHIFT),
        .head_bit  (head_bit)
    );

    // outputs
    always_comb begin
        busy     = (state_q == ST_CONVERT);
        nap      = (state_q == ST_NAP);
        sdo_oe   = (state_q == ST_SHIFT);
        sdo_data = sdo_oe & head_bit;
        viol     = viol_q;
    end
endmodule

// File: rtl/adcp_checker.sv
module adcp_checker #(
    parameter int CONV_CYCLES = 260
) (
    input logic clk,
    input logic rst_n,
    input logic conv,
    input logic busy,
    input logic nap,
    input logic sdo_oe,
    input logic sdo_data,
    input logic viol
);
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_run <= '0;
        else if (busy)
            busy_run <= busy_run + 1;
        else
            busy_run <= '0;
    end

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (conv && !$past(conv)) |=> busy);

    p_hiz_conv_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conv) |-> !sdo_oe);

    p_enable_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv && $past(conv)) |=> sdo_oe);

    p_busy_nap_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && nap));

    p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !viol) |-> (busy_run == 32'(CONV_CYCLES)));

    p_viol_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> !sdo_data);
endmodule

bind adc_serial_port adcp_checker #(.CONV_CYCLES(CONV_CYCLES)) i_adcp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv     (conv),
    .busy     (busy),
    .nap      (nap),
    .sdo_oe   (sdo_oe),
    .sdo_data (sdo_data),
    .viol     (viol)
);

// File: tb/test_adc_serial_port.sv
`timescale 1ns/1ps
module test_adc_serial_port;
    localparam int CC = 260;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv = 1'b0;
    logic sck = 1'b0;
    logic signed [15:0] ain_code = '0;
    logic sdo_data, sdo_oe, busy, nap, viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    adc_serial_port #(.AIN_W(16), .RES(14), .CONV_CYCLES(CC)) i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .ain_code(ain_code),
        .sdo_data(sdo_data), .sdo_oe(sdo_oe), .busy(busy), .nap(nap), .viol(viol)
    );

    function automatic int clampv(int v);
        if (v < 0) return 0;
        if (v > 16383) return 16383;
        return v;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic frame(int v, bit early, int nbits);
        int word;
        int cnt;
        int prev;
        int expb;
        string tag;
        word = early ? 0 : clampv(v);
        tag = (v < 0 || v > 16383) ? "R8 clamp" : "R4 bit";
        ain_code = 16'(v);
        conv = 1'b1;
        tick();
        chk(busy == 1'b1, "R1 busy after rise", int'(busy), 1);
        chk(sdo_oe == 1'b0, "R2 R9 pin off after rise", int'(sdo_oe), 0);
        chk(viol == 1'b0, "R7 viol cleared by rise", int'(viol), 0);
        ain_code = 16'($urandom);
        if (early) begin
            repeat (3) tick();
            conv = 1'b0;
            tick();
            chk(viol == 1'b1, "R7 viol set", int'(viol), 1);
            chk(busy == 1'b0, "R7 busy dropped", int'(busy), 0);
            chk(sdo_oe == 1'b1 && sdo_data == 1'b0, "R7 zero first bit", int'(sdo_data), 0);
        end else begin
            cnt = 1;
            while (busy && cnt < CC + 10) begin
                tick();
                if (busy) cnt++;
            end
            chk(cnt == CC, "R6 busy length", cnt, CC);
            chk(nap == 1'b1, "R6 nap after conversion", int'(nap), 1);
            chk(sdo_oe == 1'b0, "R2 pin off while conv high", int'(sdo_oe), 0);
            repeat (2) tick();
            conv = 1'b0;
            tick();
            chk(sdo_oe == 1'b1, "R3 pin enabled", int'(sdo_oe), 1);
            chk(int'(sdo_data) == ((word >> 13) & 1), "R3 MSB", int'(sdo_data), (word >> 13) & 1);
            chk(nap == 1'b0, "R6 nap ends at fall", int'(nap), 0);
        end
        for (int i = 1; i <= nbits; i++) begin
            prev = int'(sdo_data);
            sck = 1'b1;
            tick();
            chk(int'(sdo_data) == prev, "R4 rise holds data", int'(sdo_data), prev);
            sck = 1'b0;
            tick();
            expb = (i <= 13) ? ((word >> (13 - i)) & 1) : 0;
            if (early)
                chk(int'(sdo_data) == expb, "R7 zero frame", int'(sdo_data), expb);
            else if (i > 13)
                chk(int'(sdo_data) == expb, "R5 zero fill", int'(sdo_data), expb);
            else
                chk(int'(sdo_data) == expb, tag, int'(sdo_data), expb);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk(busy == 0 && nap == 0 && sdo_oe == 0 && viol == 0, "R2 reset state",
            int'({busy, nap, sdo_oe, viol}), 0);

        frame(16'h2AAA, 1'b0, 20);
        frame(-500, 1'b0, 14);
        frame(30000, 1'b0, 16);
        frame(16383, 1'b1, 15);
        frame(16383, 1'b0, 13);
        frame(5, 1'b0, 5);
        frame(9000, 1'b0, 0);
        for (int k = 0; k < 14; k++) begin
            int v;
            v = int'($urandom_range(22000)) - 2000;
            frame(v, ($urandom_range(5) == 0), int'($urandom_range(20)));
        end
        conv = 1'b0;
        repeat (3) tick();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule